// File: doc/BRIEF.md
# Eight-Line Fixed-Priority Interrupt Controller

This block gathers eight interrupt request lines, ranks them with a fixed priority (line 0 highest) and raises a single interrupt output toward a processor. The processor takes the interrupt with a one-cycle acknowledge pulse. One cycle later the block returns an 8-bit vector, which is a programmable base plus the number of the winning line. While that line is being serviced, the block tracks it in an in-service register. Service ends either with a specific end-of-interrupt command from software or, in automatic mode, without any command at all.

Software reaches the block through a byte-wide port at two addresses. Address 0 is the command port and address 1 is the mask/data port. A fixed four-write start-up sequence sets the vector base, the cascade word and the mode. Later command writes select what a command-port read returns, either the latched requests or the in-service lines, and they retire service levels. Later data writes load the mask. The cascade word is only stored and exposed for the surrounding logic. For a master it is a bitmap of the inputs that carry a second controller. For a slave it is the input number it drives.

If a request drops before it is acknowledged, the acknowledge still completes. In that case the block answers with the line-7 vector, and it does so even when line 7 is masked.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the latched requests and in-service lines are all zero, command-port reads return the latched requests, `intOut` and `vecValid` are low, and `cascCfg` is 0.
- R2: A write of 0x11 to address 0 starts initialization. It clears the mask and the in-service register, selects the latched requests for command-port reads and cancels a pending vector. The next three writes to address 1 load, in order, the vector base, the cascade word and the mode word, where mode bit 1 = 1 selects automatic end-of-interrupt. Until the third of these writes, `intOut` stays low and acknowledges are ignored.
- R3: `cascCfg` shows the cascade word loaded by the second data write of the initialization sequence.
- R4: A rising edge on `irqIn[n]` sets latched request bit n. That bit clears when an acknowledge selects line n.
- R5: `intOut` is high when some line n has its request bit latched, its input still high, its mask bit 0, and no in-service bit at index n or lower. Line 0 has the highest priority.
- R6: An acknowledge with a winning line n gives `vecValid` high for exactly the next cycle, with `vecOut` = (base + n) mod 256. Unless automatic mode is on, it also sets in-service bit n.
- R7: In automatic end-of-interrupt mode, an acknowledge leaves the in-service register unchanged.
- R8: An acknowledge with no qualifying line returns base + 7 and leaves the in-service register unchanged, whatever the mask of line 7.
- R9: A write of 0x60 + n (n = 0..7) to address 0 clears in-service bit n only. If an acknowledge sets the same bit in that cycle, the clear wins.
- R10: A command write of 0x0A makes later command-port reads return the latched requests, and 0x0B makes them return the in-service register. The choice holds until changed. Reads at address 1 return the mask.
- R11: Outside initialization, a write to address 1 loads the mask, where 1 blocks a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 1 | 0 = command port, 1 = mask/data port |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the port selected by `addr` |
| irqIn | input | 8 | Interrupt request lines, edge-latched |
| intOut | output | 1 | Interrupt request toward the processor |
| intAck | input | 1 | One-cycle acknowledge pulse |
| vecValid | output | 1 | Vector valid, one cycle after acknowledge |
| vecOut | output | 8 | Acknowledged vector |
| cascCfg | output | 8 | Stored cascade word |

## Verification
A wrong in-service bit shows up on `intOut` straight away. It either blocks lower-priority lines that should be forwarded or lets them through when they should be held. It also appears in a command-port read once 0x0B is selected. A wrong latched request or a wrong start-up step shows up one cycle after the next acknowledge as a vector that differs from the model, so each cycle's outputs are compared against an independent model. A wrong mask is visible at once through a read at address 1.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int DATA_W = 8;
  localparam int LINES  = 8;
  localparam int LVL_W  = $clog2(LINES);

  localparam logic [DATA_W-1:0] CMD_INIT   = 8'h11;
  localparam logic [DATA_W-1:0] CMD_RD_IRR = 8'h0A;
  localparam logic [DATA_W-1:0] CMD_RD_ISR = 8'h0B;
  localparam logic [4:0]        EOI_TAG    = 5'b01100;
  localparam int                AUTO_BIT   = 1;

  typedef enum logic [1:0] {
    ST_IDLE, ST_WAIT_BASE, ST_WAIT_CASC, ST_WAIT_MODE
  } initState_t;

  typedef struct packed {
    logic             initStart;
    logic             loadBase;
    logic             loadCasc;
    logic             loadMode;
    logic             loadMask;
    logic             selIsr;
    logic             selIrr;
    logic             eoiGo;
    logic [LVL_W-1:0] eoiLevel;
    logic             ackGo;
    logic             busy;
  } ctlStrobes_t;
endpackage

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              intAck,
  output ctlStrobes_t       strb
);
  initState_t stQ, stD;
  logic cmdWr, dataWr, startHit;

  assign cmdWr    = wrEn && !addr;
  assign dataWr   = wrEn && addr;
  assign startHit = cmdWr && (wrData == CMD_INIT);

  always_comb begin
    strb           = '0;
    strb.initStart = startHit;
    strb.selIrr    = cmdWr && (wrData == CMD_RD_IRR);
    strb.selIsr    = cmdWr && (wrData == CMD_RD_ISR);
    strb.eoiGo     = cmdWr && (wrData[DATA_W-1:LVL_W] == EOI_TAG);
    strb.eoiLevel  = wrData[LVL_W-1:0];
    strb.loadBase  = dataWr && (stQ == ST_WAIT_BASE);
    strb.loadCasc  = dataWr && (stQ == ST_WAIT_CASC);
    strb.loadMode  = dataWr && (stQ == ST_WAIT_MODE);
    strb.loadMask  = dataWr && (stQ == ST_IDLE);
    strb.busy      = (stQ != ST_IDLE);
    strb.ackGo     = intAck && (stQ == ST_IDLE) && !startHit;
  end

  always_comb begin
    stD = stQ;
    if (startHit) stD = ST_WAIT_BASE;
    else if (dataWr) begin
      case (stQ)
        ST_WAIT_BASE: stD = ST_WAIT_CASC;
        ST_WAIT_CASC: stD = ST_WAIT_MODE;
        ST_WAIT_MODE: stD = ST_IDLE;
        default:      stD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stQ <= ST_IDLE;
    else        stQ <= stD;
  end
endmodule

// File: rtl/irq_prio_dp.sv
module irq_prio_dp
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       strb,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LINES-1:0]  irqIn,
  output logic              intOut,
  output logic              vecValid,
  output logic [DATA_W-1:0] vecOut,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] cascOut,
  output logic [LINES-1:0]  isrVal,
  output logic [LINES-1:0]  irrVal,
  output logic [LINES-1:0]  maskVal,
  output logic              autoEoi
);
  logic [LINES-1:0]  irrQ, isrQ, maskQ, prevQ, rise;
  logic [LINES-1:0]  allowed, eligible, ackClr, isrSet, isrClr;
  logic [DATA_W-1:0] baseQ, cascQ;
  logic              autoQ, selIsrQ, hit;
  logic [LVL_W-1:0]  win;

  assign rise = irqIn & ~prevQ;

  // A line may interrupt only if no in-service bit sits at its own index or above it in priority.
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int n = 0; n < LINES; n++) begin
      seen       = seen | isrQ[n];
      allowed[n] = !seen;
    end
  end

  assign eligible = irrQ & irqIn & ~maskQ & allowed;

  always_comb begin
    win = LVL_W'(LINES - 1);
    for (int n = LINES - 1; n >= 0; n--) begin
      if (eligible[n]) win = LVL_W'(n);
    end
  end

  assign hit    = |eligible;
  assign intOut = hit && !strb.busy;

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      assign ackClr[g] = strb.ackGo && hit && (win == LVL_W'(g));
      assign isrSet[g] = ackClr[g] && !autoQ;
      assign isrClr[g] = strb.eoiGo && (strb.eoiLevel == LVL_W'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irrQ     <= '0;
      isrQ     <= '0;
      maskQ    <= '1;
      prevQ    <= '0;
      baseQ    <= '0;
      cascQ    <= '0;
      autoQ    <= 1'b0;
      selIsrQ  <= 1'b0;
      vecValid <= 1'b0;
      vecOut   <= '0;
    end else begin
      prevQ    <= irqIn;
      irrQ     <= (irrQ | rise) & ~ackClr;
      vecValid <= 1'b0;
      if (strb.ackGo) begin
        vecValid <= 1'b1;
        vecOut   <= baseQ + DATA_W'(win);
      end
      if (strb.initStart) begin
        isrQ     <= '0;
        maskQ    <= '0;
        selIsrQ  <= 1'b0;
        vecValid <= 1'b0;
      end else begin
        isrQ <= (isrQ | isrSet) & ~isrClr;
        if (strb.selIsr) selIsrQ <= 1'b1;
        if (strb.selIrr) selIsrQ <= 1'b0;
        if (strb.loadMask) maskQ <= wrData;
      end
      if (strb.loadBase) baseQ <= wrData;
      if (strb.loadCasc) cascQ <= wrData;
      if (strb.loadMode) autoQ <= wrData[AUTO_BIT];
    end
  end

  assign rdData  = addr ? maskQ : (selIsrQ ? isrQ : irrQ);
  assign cascOut = cascQ;
  assign isrVal  = isrQ;
  assign irrVal  = irrQ;
  assign maskVal = maskQ;
  assign autoEoi = autoQ;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [LINES-1:0]  irqIn,
  output logic              intOut,
  input  logic              intAck,
  output logic              vecValid,
  output logic [DATA_W-1:0] vecOut,
  output logic [DATA_W-1:0] cascCfg
);
  ctlStrobes_t      strb;
  logic [LINES-1:0] isrVal, irrVal, maskVal;
  logic             autoEoi, busy;

  assign busy = strb.busy;

  irq_prio_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .intAck(intAck), .strb(strb)
  );

  irq_prio_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .addr(addr), .wrData(wrData),
    .irqIn(irqIn), .intOut(intOut), .vecValid(vecValid), .vecOut(vecOut),
    .rdData(rdData), .cascOut(cascCfg), .isrVal(isrVal), .irrVal(irrVal),
    .maskVal(maskVal), .autoEoi(autoEoi)
  );
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wrEn,
  input logic       addr,
  input logic [7:0] wrData,
  input logic [7:0] irqIn,
  input logic       intOut,
  input logic       intAck,
  input logic       vecValid,
  input logic [7:0] isrVal,
  input logic [7:0] irrVal,
  input logic [7:0] maskVal,
  input logic       autoEoi,
  input logic       busy
);
  // R6
  vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid |-> $past(intAck));

  // R2
  quiet_in_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !intOut);

  // R5
  int_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intOut |-> (|(irrVal & irqIn & ~maskVal)));

  // R9
  eoi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !addr && wrData[7:3] == 5'b01100) |=> !isrVal[$past(wrData[2:0])]);

  // R8
  spurious_keeps_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intAck && !intOut && !busy && !wrEn) |=> $stable(isrVal));

  // R7
  auto_keeps_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intAck && intOut && autoEoi && !wrEn) |=> $stable(isrVal));

  // R11
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr && !busy) |=> (maskVal == $past(wrData)));
endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .irqIn(irqIn), .intOut(intOut), .intAck(intAck), .vecValid(vecValid),
  .isrVal(isrVal), .irrVal(irrVal), .maskVal(maskVal), .autoEoi(autoEoi),
  .busy(busy)
);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0, addr = 1'b0, intAck = 1'b0;
  logic [7:0] wrData = '0, irqIn = '0;
  logic [7:0] rdData, vecOut, cascCfg;
  logic       intOut, vecValid;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqIn(irqIn), .intOut(intOut), .intAck(intAck),
    .vecValid(vecValid), .vecOut(vecOut), .cascCfg(cascCfg)
  );

  // reference model state
  logic [7:0] mIrr = '0, mIsr = '0, mMask = 8'hFF, mBase = '0, mCasc = '0, mPrev = '0, mVec = '0;
  logic       mAuto = 0, mSelIsr = 0, mVecValid = 0;
  int         mStep = 0;

  function automatic logic [3:0] pickLine(input logic [7:0] irr, lv, msk, isr);
    logic [3:0] r;
    r = 4'h0;
    for (int n = 7; n >= 0; n--) begin
      logic higherBusy;
      higherBusy = 1'b0;
      for (int k = 0; k <= n; k++) if (isr[k]) higherBusy = 1'b1;
      if (irr[n] && lv[n] && !msk[n] && !higherBusy) r = {1'b1, 3'(n)};
    end
    return r;
  endfunction

  function automatic logic expIntOut();
    logic [3:0] p;
    p = pickLine(mIrr, irqIn, mMask, mIsr);
    return (mStep == 0) && p[3];
  endfunction

  function automatic logic [7:0] expRead();
    if (addr) return mMask;
    return mSelIsr ? mIsr : mIrr;
  endfunction

  // update the model for the coming clock edge
  task automatic modelEdge();
    logic [3:0] p;
    logic [7:0] rise;
    logic       initHit;
    rise    = irqIn & ~mPrev;
    mPrev   = irqIn;
    initHit = wrEn && !addr && wrData == 8'h11;
    p       = pickLine(mIrr, irqIn, mMask, mIsr);
    mIrr    = mIrr | rise;
    mVecValid = 0;
    if (intAck && mStep == 0 && !initHit) begin
      mVecValid = 1;
      if (p[3]) begin
        mVec = mBase + 8'(p[2:0]);
        mIrr[p[2:0]] = 1'b0;
        if (!mAuto) mIsr[p[2:0]] = 1'b1;
      end else mVec = mBase + 8'd7;
    end
    if (wrEn && !addr) begin
      if (initHit) begin
        mStep = 1; mMask = '0; mIsr = '0; mSelIsr = 0; mVecValid = 0;
      end else if (wrData == 8'h0A) mSelIsr = 0;
      else if (wrData == 8'h0B) mSelIsr = 1;
      else if (wrData[7:3] == 5'b01100) mIsr[wrData[2:0]] = 1'b0;
    end else if (wrEn && addr) begin
      case (mStep)
        1: begin mBase = wrData; mStep = 2; end
        2: begin mCasc = wrData; mStep = 3; end
        3: begin mAuto = wrData[1]; mStep = 0; end
        default: mMask = wrData;
      endcase
    end
  endtask

  task automatic checkOne(input string tag, input string what, input logic [7:0] got, exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    checkOne(tag, "intOut R5", {7'd0, intOut}, {7'd0, expIntOut()});
    checkOne(tag, "rdData R10", rdData, expRead());
    checkOne(tag, "vecValid R6", {7'd0, vecValid}, {7'd0, mVecValid});
    if (mVecValid) checkOne(tag, "vecOut R6", vecOut, mVec);
    checkOne(tag, "cascCfg R3", cascCfg, mCasc);
  endtask

  // inputs are already set at a falling edge; run one clock and compare
  task automatic tick(input string tag);
    modelEdge();
    @(posedge clk);
    #2;
    compareAll(tag);
    @(negedge clk);
    wrEn = 0;
    intAck = 0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d, input string tag);
    wrEn = 1; addr = a; wrData = d;
    tick(tag);
  endtask

  task automatic ack(input string tag);
    intAck = 1;
    tick(tag);
  endtask

  task automatic idle(input string tag);
    tick(tag);
  endtask

  task automatic initSeq(input logic [7:0] base, casc, mode);
    wr(0, 8'h11, "R2 start");
    wr(1, base, "R2 base");
    wr(1, casc, "R3 cascade");
    wr(1, mode, "R2 mode");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state, both read ports
    addr = 0; idle("R1 reset irr");
    addr = 1; idle("R1 reset mask");

    // R2 initialization; a request arriving during it must not raise intOut
    wr(0, 8'h11, "R2 start");
    irqIn = 8'h08;
    wr(1, 8'h20, "R2 base");
    ack("R2 ack ignored");
    wr(1, 8'h04, "R3 cascade");
    wr(1, 8'h01, "R2 mode");
    addr = 0; idle("R4 latched line 3");

    // R5/R6 priority: line 1 beats line 3
    irqIn = 8'h0A; idle("R4 rise line 1");
    ack("R6 ack line 1");
    idle("R6 vector one cycle");
    wr(0, 8'h0B, "R10 select isr");
    idle("R10 isr read");
    ack("R8 blocked by isr");
    idle("R8 spurious done");
    wr(0, 8'h61, "R9 eoi line 1");
    ack("R6 ack line 3");
    wr(0, 8'h63, "R9 eoi line 3");
    wr(0, 8'h0A, "R10 select irr");

    // R11 mask everything, then spurious with line 7 masked
    wr(1, 8'hFF, "R11 mask all");
    irqIn = 8'h00; idle("R11 drop");
    irqIn = 8'h81; idle("R11 masked request");
    ack("R8 masked line 7");
    idle("R8 spurious vector");
    wr(1, 8'h00, "R11 unmask");
    ack("R6 line 0");
    wr(0, 8'h60, "R9 eoi line 0");
    // R8 request drops before acknowledge
    irqIn = 8'h00; ack("R8 dropped request");
    idle("R8 dropped vector");

    // R9 eoi in the same cycle as the acknowledge that sets that bit
    irqIn = 8'h04; idle("R9 rise line 2");
    wrEn = 1; addr = 0; wrData = 8'h62; intAck = 1; tick("R9 eoi with ack");
    wr(0, 8'h0B, "R9 isr view");

    // R7 automatic end-of-interrupt
    irqIn = 8'h00;
    initSeq(8'h40, 8'h02, 8'h03);
    wr(0, 8'h0B, "R7 isr view");
    irqIn = 8'h20; idle("R7 rise line 5");
    ack("R7 ack line 5");
    idle("R7 isr stays clear");

    // mixed random phase, normal end-of-interrupt mode
    irqIn = 8'h00;
    initSeq(8'hF8, 8'h04, 8'h01);
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4000; i++) begin
      for (int b = 0; b < 8; b++) if ($urandom_range(7) == 0) irqIn[b] = ~irqIn[b];
      intAck = ($urandom_range(3) == 0);
      if ($urandom_range(9) == 0) begin
        wrEn = 1;
        case ($urandom_range(3))
          0: begin addr = 1; wrData = 8'($urandom) & 8'($urandom); end
          1: begin addr = 0; wrData = 8'h60 | 8'($urandom_range(7)); end
          2: begin addr = 0; wrData = 8'h0B; end
          default: begin addr = 0; wrData = 8'h0A; end
        endcase
      end else addr = 1'($urandom_range(1));
      tick("R5/R6 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule